// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block turns word-wide bus accesses to one register into pin-level cycles on a raw 8-bit NAND flash device. Each accepted bus write carries three things: an operation code in bits 30:28, a chip-enable flag in bit 31 and a data byte in bits 23:16. Depending on the code, the block runs a command-latch cycle, an address-latch cycle or a data-write cycle on the flash pins, or it arms read mode. While read mode is armed, every bus read runs one flash read strobe and returns the fetched byte. Every read response also reports the flash ready/busy line.

The bus side uses two valid/ready channels. A request (`req_*`) is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a flash cycle runs or a read response waits, so the host stalls and no request is lost. A read response (`rsp_*`) stays valid, with its data unchanged, until the host raises `rsp_ready`. The flash data bus is split into an input, an output and an output enable, and these are joined to a tri-state pad outside the block. The lengths of the setup, strobe and hold phases are parameters counted in system clocks.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1, `nand_io_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A write with bits 30:28 = 0 runs a command-latch cycle. `nand_cle` is high and `nand_ale` is low for the whole cycle, and `nand_io_out` carries bits 23:16 of the word with `nand_io_oe` high while `nand_we_n` is low.
- R3: A write with bits 30:28 = 1 runs an address-latch cycle, with `nand_ale` high, `nand_cle` low and bits 23:16 driven on `nand_io_out`.
- R4: A write with bits 30:28 = 3 runs exactly one data-write cycle. Both `nand_cle` and `nand_ale` are low and bits 23:16 are driven on the I/O bus.
- R5: Every accepted write sets `nand_ce_n` to the inverse of bit 31 of the word, and `nand_ce_n` keeps that value until the next accepted write.
- R6: A write with bits 30:28 = 2 arms read mode and produces no flash strobe. Each later bus read then produces one `nand_re_n` low pulse, and the byte sampled from `nand_io_in` is returned in bits 23:16 of the response.
- R7: Read mode stays armed across any number of reads. A write with any other code disarms it. A read while disarmed produces no `nand_re_n` pulse and returns 0 in bits 23:16.
- R8: In a read response, bit 15 is 1 when `nand_rb_n` is low (busy) and 0 when it is high. Bits 31:24 and 14:0 are always 0.
- R9: `req_ready` is low from the edge that accepts a cycle-producing request until that cycle ends. Back-to-back writes each produce their own strobe, in order.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_rdata` stays stable and no new request is accepted.
- R11: `nand_we_n` and `nand_re_n` go low for exactly PULSE_CYC clocks. They are never low together, and `nand_cle` and `nand_ale` are never high together.
- R12: A write with code 4 to 7 produces no flash strobe and disarms read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request can be accepted |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_wdata | input | 32 | Write word: [31] chip enable, [30:28] op, [23:16] byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts read response |
| rsp_rdata | output | 32 | Read word: [23:16] byte, [15] busy |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven toward the flash |
| nand_io_oe | output | 1 | Output enable for the flash I/O pad |
| nand_io_in | input | 8 | Byte from the flash I/O pad |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
On every cycle, the embedded assertions check the pin rules: the two strobes are never low together, the two latch enables are never high together, the I/O bus is driven and stable while the write strobe is low, a cycle starts only from idle, and a stalled response holds its value. Other behaviour can only be shown by the directed scenarios. These cover how each operation code maps to a pin cycle and a byte, how long each strobe lasts, when read mode is armed and when it is disarmed, the bytes fetched from the flash, the busy bit and the chip-enable level.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  localparam logic [2:0] OP_CMD   = 3'd0;
  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_ARMRD = 3'd2;
  localparam logic [2:0] OP_WDATA = 3'd3;

  function automatic logic [31:0] pack_rsp(input logic [7:0] b, input logic busy);
    return {8'h00, b, busy, 15'h0000};
  endfunction
endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
  import nand_bridge_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_rd,
  input  logic       start_cle,
  input  logic       start_ale,
  input  logic [7:0] start_byte,
  output logic       busy,
  output logic       done,
  output logic       done_rd,
  output logic [7:0] rd_byte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  input  logic [7:0] io_in
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);

  phase_e        ph_q, ph_d;
  logic          rd_q, cle_q, ale_q;
  logic [7:0]    byte_q;
  logic          t_load, t_zero;
  logic [CW-1:0] t_val;

  nand_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  always_comb begin
    ph_d   = ph_q;
    t_load = 1'b0;
    t_val  = LD_SETUP;
    unique case (ph_q)
      PH_IDLE:  if (start)  begin ph_d = PH_SETUP; t_load = 1'b1; t_val = LD_SETUP; end
      PH_SETUP: if (t_zero) begin ph_d = PH_PULSE; t_load = 1'b1; t_val = LD_PULSE; end
      PH_PULSE: if (t_zero) begin ph_d = PH_HOLD;  t_load = 1'b1; t_val = LD_HOLD;  end
      PH_HOLD:  if (t_zero) begin ph_d = PH_IDLE; end
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      rd_q    <= 1'b0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      byte_q  <= '0;
      rd_byte <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_IDLE && start) begin
        rd_q   <= start_rd;
        cle_q  <= start_cle & ~start_rd;
        ale_q  <= start_ale & ~start_rd;
        byte_q <= start_byte;
      end
      if (ph_q == PH_PULSE && t_zero && rd_q) rd_byte <= io_in;
    end
  end

  assign busy    = (ph_q != PH_IDLE);
  assign done    = (ph_q == PH_HOLD) && t_zero;
  assign done_rd = done && rd_q;
  assign cle     = busy && cle_q;
  assign ale     = busy && ale_q;
  assign io_oe   = busy && !rd_q;
  assign io_out  = io_oe ? byte_q : 8'h00;
  assign we_n    = !((ph_q == PH_PULSE) && !rd_q);
  assign re_n    = !((ph_q == PH_PULSE) && rd_q);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R11
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R11
  AST_IO_DRIVEN_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> io_oe); // R2
  AST_IO_STABLE_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(io_out)); // R4
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R9
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nand_bridge_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb_n
);
  logic       accept, armed_q, ce_q;
  logic [2:0] op;
  logic       op_strobes, seq_start;
  logic       seq_busy, seq_done, seq_done_rd;
  logic [7:0] seq_rbyte;

  assign op         = req_wdata[30:28];
  assign accept     = req_valid && req_ready;
  assign op_strobes = (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WDATA);
  assign seq_start  = accept && (req_write ? op_strobes : armed_q);
  assign req_ready  = !seq_busy && !rsp_valid;
  assign nand_ce_n  = !ce_q;

  nand_pin_seq #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(seq_start), .start_rd(!req_write),
    .start_cle(op == OP_CMD), .start_ale(op == OP_ADDR),
    .start_byte(req_wdata[23:16]),
    .busy(seq_busy), .done(seq_done), .done_rd(seq_done_rd), .rd_byte(seq_rbyte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .io_in(nand_io_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b0;
      armed_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept && req_write) begin
        ce_q    <= req_wdata[31];
        armed_q <= (op == OP_ARMRD);
      end
      if (accept && !req_write && !armed_q) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= pack_rsp(8'h00, !nand_rb_n);
      end
      if (seq_done_rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= pack_rsp(seq_rbyte, !nand_rb_n);
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
  AST_RSP_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:24] == 8'h00 && rsp_rdata[14:0] == 15'h0)); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_busy); // R9
endmodule

// File: tb/nand_reg_bridge_test.sv
`timescale 1ns/100ps
module nand_reg_bridge_test;
  localparam int PULSE = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, nand_rb_n = 1;
  logic [31:0] req_wdata = '0;
  logic [7:0]  flash_q = 8'h00;
  logic req_ready, rsp_valid, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [31:0] rsp_rdata;
  logic [7:0]  nand_io_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(flash_q), .nand_rb_n(nand_rb_n)
  );

  // strobe monitor
  int we_w = 0, we_last_w = 0, we_pulses = 0, re_w = 0, re_last_w = 0, re_pulses = 0;
  logic m_cle, m_ale, m_oe;
  logic [7:0] m_io;
  logic [7:0] io_log [0:7];
  always @(negedge clk) begin
    if (!nand_we_n) begin
      we_w++; m_cle = nand_cle; m_ale = nand_ale; m_io = nand_io_out; m_oe = nand_io_oe;
    end else if (we_w != 0) begin
      we_last_w = we_w; io_log[we_pulses % 8] = m_io; we_pulses++; we_w = 0;
    end
    if (!nand_re_n) re_w++;
    else if (re_w != 0) begin re_last_w = re_w; re_pulses++; re_w = 0; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input bit wr, input logic [31:0] w);
    step();
    req_valid = 1; req_write = wr; req_wdata = w;
    while (!req_ready) step();
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic bus_write(input logic [31:0] w);
    issue(1, w);
    step();
    while (!req_ready) step();
    step();
  endtask

  task automatic bus_read(output logic [31:0] d);
    issue(0, '0);
    step();
    while (!rsp_valid) step();
    d = rsp_rdata;
    step();
  endtask

  function automatic logic [31:0] wword(input bit ce, input logic [2:0] op, input logic [7:0] b);
    return {ce, op, 4'h0, b, 16'h0000};
  endfunction

  task automatic t_reset();
    check(nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_io_oe
          && req_ready && !rsp_valid, "R1 reset pins",
          {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, req_ready, rsp_valid},
          32'b10011010);
  endtask

  task automatic t_cmd_addr_data();
    int p;
    p = we_pulses;
    bus_write(wword(1, 3'd0, 8'h70));
    check(we_pulses == p + 1 && m_cle && !m_ale && m_io == 8'h70 && m_oe, "R2 command cycle",
          {m_cle, m_ale, m_oe, m_io}, {3'b101, 8'h70});
    check(we_last_w == PULSE, "R11 we pulse width", we_last_w, PULSE);
    check(!nand_ce_n, "R5 ce low with bit31", nand_ce_n, 0);
    bus_write(wword(1, 3'd1, 8'h5A));
    check(we_pulses == p + 2 && !m_cle && m_ale && m_io == 8'h5A, "R3 address cycle",
          {m_cle, m_ale, m_io}, {2'b01, 8'h5A});
    bus_write(wword(1, 3'd3, 8'hC3));
    check(we_pulses == p + 3 && !m_cle && !m_ale && m_io == 8'hC3, "R4 data write cycle",
          {we_pulses, m_cle, m_ale, m_io}, {p + 3, 2'b00, 8'hC3});
  endtask

  task automatic t_back_to_back();
    int p;
    p = we_pulses;
    issue(1, wword(1, 3'd3, 8'h11));
    check(!req_ready, "R9 ready low during cycle", req_ready, 0);
    issue(1, wword(1, 3'd3, 8'h22));
    issue(1, wword(1, 3'd3, 8'h33));
    step(); while (!req_ready) step(); step();
    check(we_pulses == p + 3 && io_log[p % 8] == 8'h11 && io_log[(p + 1) % 8] == 8'h22
          && io_log[(p + 2) % 8] == 8'h33, "R9 back-to-back writes",
          {io_log[p % 8], io_log[(p + 1) % 8], io_log[(p + 2) % 8]}, 32'h112233);
  endtask

  task automatic t_read_mode();
    logic [31:0] d;
    int p, r;
    p = we_pulses; r = re_pulses;
    bus_write(wword(1, 3'd2, 8'h00));
    check(we_pulses == p && re_pulses == r, "R6 arm makes no strobe", we_pulses - p, 0);
    flash_q = 8'hA5; nand_rb_n = 1;
    bus_read(d);
    check(d == 32'h00A5_0000 && re_pulses == r + 1, "R6 armed read byte", d, 32'h00A50000);
    check(re_last_w == PULSE, "R11 re pulse width", re_last_w, PULSE);
    flash_q = 8'h3C; nand_rb_n = 0;
    bus_read(d);
    check(d == 32'h003C_8000 && re_pulses == r + 2, "R7 stays armed, R8 busy bit", d, 32'h003C8000);
    nand_rb_n = 1;
    bus_write(wword(1, 3'd0, 8'hFF));
    bus_read(d);
    check(d == 32'h0 && re_pulses == r + 2, "R7 disarmed by other op", d, 0);
  endtask

  task automatic t_status_only();
    logic [31:0] d;
    nand_rb_n = 0;
    bus_read(d);
    check(d == 32'h0000_8000, "R8 busy reported", d, 32'h8000);
    nand_rb_n = 1;
    bus_read(d);
    check(d == 32'h0, "R8 ready reported", d, 0);
  endtask

  task automatic t_unused_ops();
    logic [31:0] d;
    int p, r;
    bus_write(wword(1, 3'd2, 8'h00));
    p = we_pulses; r = re_pulses;
    bus_write(wword(0, 3'd5, 8'h99));
    check(we_pulses == p, "R12 op5 no strobe", we_pulses - p, 0);
    check(nand_ce_n, "R5 ce high with bit31 clear", nand_ce_n, 1);
    flash_q = 8'h77;
    bus_read(d);
    check(d == 32'h0 && re_pulses == r, "R12 op5 disarms read", d, 0);
  endtask

  task automatic t_rsp_stall();
    logic [31:0] d0;
    bus_write(wword(1, 3'd2, 8'h00));
    flash_q = 8'h4E;
    rsp_ready = 0;
    issue(0, '0);
    step(); while (!rsp_valid) step();
    d0 = rsp_rdata;
    repeat (3) step();
    check(rsp_valid && rsp_rdata == d0 && !req_ready && d0 == 32'h004E_0000,
          "R10 response held", rsp_rdata, 32'h004E0000);
    rsp_ready = 1;
    step();
    check(!rsp_valid && req_ready, "R10 response released", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_cmd_addr_data();
    t_back_to_back();
    t_read_mode();
    t_status_only();
    t_unused_ops();
    t_rsp_stall();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule